// File: doc/BRIEF.md
# Fractional PLL Output Rate Calculator

This block works out the output frequency, in hertz, that a fractional-N PLL produces for a given set of divider settings. It takes the reference frequency and three packed configuration words. The first holds the integer multiplier, the pre-divider and the post-divider. The second holds the fractional numerator and the third holds the fractional denominator. A one-cycle `start` launches a job. The block returns the rate on `rate_hz` and marks completion with a one-cycle `done`.

The block has two modes. In integer mode the numerator and denominator are ignored. In fractional mode the multiplier is the integer part plus numerator over denominator. Before doing any arithmetic, the block compares the decoded fields with a small built-in table of known settings for the selected mode. On an exact match it returns that entry's nominal rate and skips the arithmetic. When nothing matches, it builds a 64-bit numerator and divisor and runs a restoring divider that produces one quotient bit per cycle.

The controller is a state machine with five states:
- `ST_IDLE` waits for `start` (IDLE→DECODE on start).
- `ST_DECODE` registers the decoded fields, the table lookup and the zero-denominator test (DECODE→RESOLVE).
- `ST_RESOLVE` ends the job at once on an error or a table hit (RESOLVE→FINISH). Otherwise it launches the divider (RESOLVE→DIVIDE).
- `ST_DIVIDE` waits for the divider (DIVIDE→FINISH on divider completion).
- `ST_FINISH` raises `done` for one cycle (FINISH→IDLE).

The divider has two states of its own: `DV_IDLE` and `DV_RUN`.

Top module: `fpll_rate_calc`

## Requirements
- R1: Field positions are fixed. In `div_word`, bits 24:16 are the multiplier (MFI), bits 15:13 the pre-divider code and bits 7:0 the post-divider code. In `num_word`, bits 31:2 are the numerator (MFN). In `den_word`, bits 29:0 are the denominator (MFD). All other bits of the three words have no effect on the result.
- R2: A post-divider code of 0 divides by 2 and a code of 1 divides by 3. Any other code divides by its own value.
- R3: A pre-divider code of 0 divides by 1, so it gives the same result as a code of 1.
- R4: With `frac_mode`=0 the result is floor(ref × MFI / (pre × post)), and MFN and MFD have no effect.
- R5: With `frac_mode`=1 the result is floor((ref × MFI × MFD + ref × MFN) / (MFD × pre × post)), taken with one final truncating division on 64-bit values.
- R6: When the decoded fields exactly match an entry of the selected mode's table, the output is that entry's nominal rate. The fractional table compares all five fields. The integer table compares MFI, the pre-divider and the post-divider only. One example is MFI=162, MFN=50, MFD=100, pre code 0, post code 6 in fractional mode, which gives 650000000. Another is MFI=141, pre code 1, post code 2 in integer mode, which gives 1700000000.
- R7: In fractional mode, MFD=0 sets `den_error` and forces `rate_hz` to 0. In integer mode a zero MFD never sets `den_error`.
- R8: `start` while idle raises `busy` on the next cycle. `done` is high for exactly one cycle per job. `rate_hz` and `den_error` hold their last result until the next job completes.
- R9: A `start` pulse while `busy` is high is ignored. The running job completes with its own result and no second job follows.
- R10: After reset `busy`, `done`, `den_error` and `rate_hz` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches a job when idle |
| frac_mode | input | 1 | 1 selects fractional mode, 0 integer mode |
| ref_hz | input | 32 | Reference frequency in Hz |
| div_word | input | 32 | Packed multiplier, pre-divider and post-divider codes |
| num_word | input | 32 | Packed fractional numerator |
| den_word | input | 32 | Packed fractional denominator |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle completion pulse |
| rate_hz | output | 64 | Computed or table rate in Hz |
| den_error | output | 1 | Zero denominator seen in fractional mode |

## Verification
Some properties are checked on every cycle:
- the one-cycle width of `done`;
- the launch of `busy` after `start`;
- the zero rate that goes with a raised `den_error`;
- the absence of `den_error` in integer mode;
- the frozen job inputs while busy;
- a non-zero divisor at launch;
- the remainder in the divider staying below the divisor.

Only the bench's scenarios can show that the arithmetic is right. These include the post-divider and pre-divider code mapping, the truncation of non-integer results, the table taking priority over a computed value that differs, and the choice of table by mode. The same holds for field isolation with junk in the unused bits, the start ignored while busy, and the state left after a reset in mid-job.

// File: rtl/fpll_pkg.sv
package fpll_pkg;

    localparam int MFI_W   = 9;
    localparam int MFN_W   = 30;
    localparam int MFD_W   = 30;
    localparam int PRE_W   = 3;
    localparam int POST_W  = 8;
    localparam int NOM_W   = 32;

    localparam int MFI_LSB  = 16;
    localparam int PRE_LSB  = 13;
    localparam int POST_LSB = 0;
    localparam int MFN_LSB  = 2;
    localparam int MFD_LSB  = 0;

    localparam int FRAC_ENTRIES = 10;
    localparam int INT_ENTRIES  = 3;

    typedef struct packed {
        logic [MFI_W-1:0]  mfi;
        logic [MFN_W-1:0]  mfn;
        logic [MFD_W-1:0]  mfd;
        logic [PRE_W-1:0]  pre;
        logic [POST_W-1:0] post;
    } fpll_cfg_t;

    typedef struct packed {
        fpll_cfg_t         cfg;
        logic [NOM_W-1:0]  nominal;
    } fpll_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_RESOLVE,
        ST_DIVIDE,
        ST_FINISH
    } fpll_state_e;

    typedef enum logic {
        DV_IDLE,
        DV_RUN
    } fpll_div_state_e;

    function automatic fpll_entry_t mk_entry(input logic [NOM_W-1:0] nominal,
                                             input int mfi, input int mfn,
                                             input int mfd, input int pre,
                                             input int post);
        fpll_entry_t e;
        e.nominal  = nominal;
        e.cfg.mfi  = MFI_W'(mfi);
        e.cfg.mfn  = MFN_W'(mfn);
        e.cfg.mfd  = MFD_W'(mfd);
        e.cfg.pre  = PRE_W'(pre);
        e.cfg.post = POST_W'(post);
        return e;
    endfunction

    // Known fractional-mode settings, listed by ascending rate.
    function automatic fpll_entry_t frac_entry(input int idx);
        case (idx)
            0:       return mk_entry(32'd300000000, 150, 0, 1, 0, 12);
            1:       return mk_entry(32'd393216000, 163, 84, 100, 0, 10);
            2:       return mk_entry(32'd400000000, 200, 0, 1, 0, 12);
            3:       return mk_entry(32'd445333333, 167, 0, 1, 0, 9);
            4:       return mk_entry(32'd484000000, 121, 0, 1, 0, 6);
            5:       return mk_entry(32'd498000000, 166, 0, 1, 0, 8);
            6:       return mk_entry(32'd519750000, 173, 25, 100, 1, 8);
            7:       return mk_entry(32'd560000000, 140, 0, 1, 0, 6);
            8:       return mk_entry(32'd594000000, 198, 0, 1, 0, 8);
            default: return mk_entry(32'd650000000, 162, 50, 100, 0, 6);
        endcase
    endfunction

    // Known integer-mode settings; numerator and denominator are not compared.
    function automatic fpll_entry_t int_entry(input int idx);
        case (idx)
            0:       return mk_entry(32'd900000000, 150, 0, 0, 1, 4);
            1:       return mk_entry(32'd1400000000, 175, 0, 0, 1, 3);
            default: return mk_entry(32'd1700000000, 141, 0, 0, 1, 2);
        endcase
    endfunction

endpackage

// File: rtl/fpll_field_decode.sv
module fpll_field_decode
    import fpll_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] div_word,
    input  logic [WORD_W-1:0] num_word,
    input  logic [WORD_W-1:0] den_word,
    output fpll_cfg_t         cfg,
    output logic [PRE_W-1:0]  pre_eff,
    output logic [POST_W-1:0] post_eff
);

    logic unused_bits;

    always_comb begin
        cfg.mfi  = div_word[MFI_LSB  +: MFI_W];
        cfg.pre  = div_word[PRE_LSB  +: PRE_W];
        cfg.post = div_word[POST_LSB +: POST_W];
        cfg.mfn  = num_word[MFN_LSB  +: MFN_W];
        cfg.mfd  = den_word[MFD_LSB  +: MFD_W];
    end

    // Pre-divider code 0 behaves as divide-by-1.
    always_comb begin
        pre_eff = (cfg.pre == '0) ? PRE_W'(1) : cfg.pre;
    end

    // Post-divider codes 0 and 1 are remapped to 2 and 3.
    always_comb begin
        unique case (cfg.post)
            POST_W'(0): post_eff = POST_W'(2);
            POST_W'(1): post_eff = POST_W'(3);
            default:    post_eff = cfg.post;
        endcase
    end

    assign unused_bits = ^{div_word[WORD_W-1:MFI_LSB+MFI_W],
                           div_word[PRE_LSB-1:POST_LSB+POST_W],
                           num_word[MFN_LSB-1:0],
                           den_word[WORD_W-1:MFD_LSB+MFD_W]};

endmodule

// File: rtl/fpll_table_match.sv
module fpll_table_match
    import fpll_pkg::*;
(
    input  fpll_cfg_t         cfg,
    input  logic              frac_mode,
    output logic              hit,
    output logic [NOM_W-1:0]  nominal
);

    logic [FRAC_ENTRIES-1:0] frac_hit;
    logic [INT_ENTRIES-1:0]  int_hit;
    logic [NOM_W-1:0]        frac_rate [FRAC_ENTRIES];
    logic [NOM_W-1:0]        int_rate  [INT_ENTRIES];

    for (genvar i = 0; i < FRAC_ENTRIES; i++) begin : g_frac
        localparam fpll_entry_t ENT = frac_entry(i);
        assign frac_hit[i]  = (cfg == ENT.cfg);
        assign frac_rate[i] = ENT.nominal;
    end

    for (genvar j = 0; j < INT_ENTRIES; j++) begin : g_int
        localparam fpll_entry_t ENT = int_entry(j);
        assign int_hit[j]  = (cfg.mfi == ENT.cfg.mfi) &&
                             (cfg.pre == ENT.cfg.pre) &&
                             (cfg.post == ENT.cfg.post);
        assign int_rate[j] = ENT.nominal;
    end

    // Lowest index wins if two entries ever match.
    always_comb begin
        hit     = 1'b0;
        nominal = '0;
        if (frac_mode) begin
            for (int i = FRAC_ENTRIES - 1; i >= 0; i--) begin
                if (frac_hit[i]) begin
                    hit     = 1'b1;
                    nominal = frac_rate[i];
                end
            end
        end else begin
            for (int j = INT_ENTRIES - 1; j >= 0; j--) begin
                if (int_hit[j]) begin
                    hit     = 1'b1;
                    nominal = int_rate[j];
                end
            end
        end
    end

endmodule

// File: rtl/fpll_divider.sv
module fpll_divider
    import fpll_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         fin,
    output logic [W-1:0] quotient
);

    localparam int CW = $clog2(W + 1);

    fpll_div_state_e st_q;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  den_q;
    logic [CW-1:0] cnt_q;
    logic          fin_q;

    logic [W:0]    shifted;
    logic          take;
    logic [W-1:0]  rem_n;

    // One restoring step: shift in next dividend bit, subtract if it fits.
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        take    = (shifted >= {1'b0, den_q});
        rem_n   = take ? W'(shifted - {1'b0, den_q}) : shifted[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= DV_IDLE;
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            unique case (st_q)
                DV_IDLE: begin
                    if (go) begin
                        rem_q <= '0;
                        quo_q <= dividend;
                        den_q <= divisor;
                        cnt_q <= CW'(W);
                        st_q  <= DV_RUN;
                    end
                end
                DV_RUN: begin
                    rem_q <= rem_n;
                    quo_q <= {quo_q[W-2:0], take};
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CW'(1)) begin
                        st_q  <= DV_IDLE;
                        fin_q <= 1'b1;
                    end
                end
                default: st_q <= DV_IDLE;
            endcase
        end
    end

    assign busy     = (st_q == DV_RUN);
    assign fin      = fin_q;
    assign quotient = quo_q;

    assert_divisor_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (go && st_q == DV_IDLE) |-> (divisor != '0));

    assert_rem_below_divisor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DV_RUN) |-> (rem_q < den_q));

endmodule

// File: rtl/fpll_rate_calc.sv
module fpll_rate_calc
    import fpll_pkg::*;
#(
    parameter int REF_W  = 32,
    parameter int WORD_W = 32,
    parameter int RATE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              frac_mode,
    input  logic [REF_W-1:0]  ref_hz,
    input  logic [WORD_W-1:0] div_word,
    input  logic [WORD_W-1:0] num_word,
    input  logic [WORD_W-1:0] den_word,
    output logic              busy,
    output logic              done,
    output logic [RATE_W-1:0] rate_hz,
    output logic              den_error
);

    fpll_state_e state_q, state_n;

    // Job inputs captured at launch
    logic              frac_q;
    logic [REF_W-1:0]  ref_q;
    logic [WORD_W-1:0] divw_q, numw_q, denw_q;

    // Decoded and registered
    fpll_cfg_t         cfg_d, cfg_q;
    logic [PRE_W-1:0]  pre_d, pre_q;
    logic [POST_W-1:0] post_d, post_q;
    logic              hit_d, hit_q;
    logic [NOM_W-1:0]  nom_d, nom_q;
    logic              zero_q;

    // Results
    logic [RATE_W-1:0] rate_q;
    logic              err_q;

    // Divider link
    logic              div_go, div_busy, div_fin;
    logic [RATE_W-1:0] dividend, divisor, quotient;

    fpll_field_decode #(.WORD_W(WORD_W)) u_decode (
        .div_word (divw_q),
        .num_word (numw_q),
        .den_word (denw_q),
        .cfg      (cfg_d),
        .pre_eff  (pre_d),
        .post_eff (post_d)
    );

    fpll_table_match u_table (
        .cfg       (cfg_d),
        .frac_mode (frac_q),
        .hit       (hit_d),
        .nominal   (nom_d)
    );

    // Numerator and divisor built from registered fields.
    always_comb begin
        logic [RATE_W-1:0] ref_x, mfi_x, mfn_x, mfd_x, pre_x, post_x;
        ref_x  = RATE_W'(ref_q);
        mfi_x  = RATE_W'(cfg_q.mfi);
        mfn_x  = RATE_W'(cfg_q.mfn);
        mfd_x  = RATE_W'(cfg_q.mfd);
        pre_x  = RATE_W'(pre_q);
        post_x = RATE_W'(post_q);
        if (frac_q) begin
            dividend = ref_x * mfi_x * mfd_x + ref_x * mfn_x;
            divisor  = mfd_x * pre_x * post_x;
        end else begin
            dividend = ref_x * mfi_x;
            divisor  = pre_x * post_x;
        end
    end

    assign div_go = (state_q == ST_RESOLVE) && !zero_q && !hit_q;

    fpll_divider #(.W(RATE_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (dividend),
        .divisor  (divisor),
        .busy     (div_busy),
        .fin      (div_fin),
        .quotient (quotient)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_n = ST_DECODE;
            ST_DECODE:  state_n = ST_RESOLVE;
            ST_RESOLVE: state_n = (zero_q || hit_q) ? ST_FINISH : ST_DIVIDE;
            ST_DIVIDE:  if (div_fin) state_n = ST_FINISH;
            ST_FINISH:  state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frac_q <= 1'b0;
            ref_q  <= '0;
            divw_q <= '0;
            numw_q <= '0;
            denw_q <= '0;
            cfg_q  <= '0;
            pre_q  <= '0;
            post_q <= '0;
            hit_q  <= 1'b0;
            nom_q  <= '0;
            zero_q <= 1'b0;
            rate_q <= '0;
            err_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        frac_q <= frac_mode;
                        ref_q  <= ref_hz;
                        divw_q <= div_word;
                        numw_q <= num_word;
                        denw_q <= den_word;
                    end
                end
                ST_DECODE: begin
                    cfg_q  <= cfg_d;
                    pre_q  <= pre_d;
                    post_q <= post_d;
                    hit_q  <= hit_d;
                    nom_q  <= nom_d;
                    zero_q <= frac_q && (cfg_d.mfd == '0);
                end
                ST_RESOLVE: begin
                    if (zero_q) begin
                        rate_q <= '0;
                        err_q  <= 1'b1;
                    end else if (hit_q) begin
                        rate_q <= RATE_W'(nom_q);
                        err_q  <= 1'b0;
                    end
                end
                ST_DIVIDE: begin
                    if (div_fin) begin
                        rate_q <= quotient;
                        err_q  <= 1'b0;
                    end
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_FINISH);
    assign rate_hz   = rate_q;
    assign den_error = err_q;

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_start_launches_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_err_zero_rate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && den_error) |-> (rate_hz == '0));

    assert_int_no_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !frac_q) |-> !den_error);

    assert_job_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(divw_q) && $stable(ref_q) && $stable(frac_q)));

    assert_div_only_when_dividing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> (state_q == ST_DIVIDE));

endmodule

// File: tb/fpll_rate_calc_bench.sv
module fpll_rate_calc_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;
    localparam int WAIT_LIMIT = 400;

    typedef struct packed {
        logic        frac;
        logic [31:0] fref;
        logic [8:0]  mfi;
        logic [29:0] mfn;
        logic [29:0] mfd;
        logic [2:0]  pre;
        logic [7:0]  post;
        logic [63:0] exp_rate;
        logic        exp_err;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 32'd24000000, 9'd162, 30'd50, 30'd100, 3'd0, 8'd6,   64'd650000000,  1'b0},
        '{1'b1, 32'd24000000, 9'd173, 30'd25, 30'd100, 3'd1, 8'd8,   64'd519750000,  1'b0},
        '{1'b1, 32'd24000000, 9'd100, 30'd1,  30'd3,   3'd0, 8'd7,   64'd344000000,  1'b0},
        '{1'b1, 32'd24000000, 9'd100, 30'd1,  30'd7,   3'd3, 8'd9,   64'd89015873,   1'b0},
        '{1'b0, 32'd24000000, 9'd100, 30'd0,  30'd0,   3'd2, 8'd0,   64'd600000000,  1'b0},
        '{1'b0, 32'd24000000, 9'd150, 30'd0,  30'd0,   3'd0, 8'd1,   64'd1200000000, 1'b0},
        '{1'b0, 32'd24000000, 9'd141, 30'd0,  30'd0,   3'd1, 8'd2,   64'd1700000000, 1'b0},
        '{1'b0, 32'd24000000, 9'd125, 30'd77, 30'd0,   3'd1, 8'd5,   64'd600000000,  1'b0},
        '{1'b1, 32'd24000000, 9'd100, 30'd5,  30'd0,   3'd1, 8'd4,   64'd0,          1'b1},
        '{1'b0, 32'd24000000, 9'd162, 30'd50, 30'd100, 3'd0, 8'd6,   64'd648000000,  1'b0},
        '{1'b0, 32'd19200000, 9'd200, 30'd0,  30'd0,   3'd0, 8'd4,   64'd960000000,  1'b0},
        '{1'b0, 32'd19200000, 9'd200, 30'd0,  30'd0,   3'd1, 8'd4,   64'd960000000,  1'b0},
        '{1'b1, 32'd24000000, 9'd100, 30'd0,  30'd1,   3'd0, 8'd0,   64'd1200000000, 1'b0},
        '{1'b0, 32'd24000000, 9'd500, 30'd3,  30'd9,   3'd7, 8'd200, 64'd8571428,    1'b0}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 6, 9: return "R6";
            2, 3:       return "R5";
            4, 5, 12:   return "R2";
            7:          return "R4";
            8:          return "R7";
            10, 11:     return "R3";
            default:    return "R1";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        frac_mode = 1'b0;
    logic [31:0] ref_hz = '0;
    logic [31:0] div_word = '0;
    logic [31:0] num_word = '0;
    logic [31:0] den_word = '0;
    logic        busy, done, den_error;
    logic [63:0] rate_hz;

    int checks = 0;
    int errors = 0;
    int done_count = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (rst_n && done) done_count <= done_count + 1;

    fpll_rate_calc u_fpll_rate_calc (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .frac_mode (frac_mode),
        .ref_hz    (ref_hz),
        .div_word  (div_word),
        .num_word  (num_word),
        .den_word  (den_word),
        .busy      (busy),
        .done      (done),
        .rate_hz   (rate_hz),
        .den_error (den_error)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Unused bits are filled with junk to show they have no effect (R1).
    task automatic drive_vec(input vec_t v);
        frac_mode = v.frac;
        ref_hz    = v.fref;
        div_word  = {7'h55, v.mfi, v.pre, 5'h1f, v.post};
        num_word  = {v.mfn, 2'b11};
        den_word  = {2'b10, v.mfd};
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req, output bit ok);
        ok = 1'b0;
        for (int n = 0; n < WAIT_LIMIT; n++) begin
            if (done) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
        if (!ok) check(req, "done timeout", 64'd0, 64'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit ok;
        int dc;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "busy after reset", {63'd0, busy}, 64'd0);
        check("R10", "done after reset", {63'd0, done}, 64'd0);
        check("R10", "rate after reset", rate_hz, 64'd0);
        check("R10", "err after reset", {63'd0, den_error}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table-driven vectors
        for (int i = 0; i < NVEC; i++) begin
            drive_vec(VECS[i]);
            pulse_start();
            check("R8", "busy after start", {63'd0, busy}, 64'd1);
            wait_done(vec_tag(i), ok);
            if (ok) begin
                check(vec_tag(i), $sformatf("rate vec %0d", i), rate_hz, VECS[i].exp_rate);
                check(vec_tag(i), $sformatf("err vec %0d", i), {63'd0, den_error},
                      {63'd0, VECS[i].exp_err});
                @(negedge clk);
                check("R8", "done one cycle", {63'd0, done}, 64'd0);
                repeat (3) @(negedge clk);
                check("R8", "rate held", rate_hz, VECS[i].exp_rate);
            end
        end

        // R9: start while busy is ignored
        drive_vec(VECS[2]);
        pulse_start();
        repeat (5) @(negedge clk);
        drive_vec(VECS[0]);
        pulse_start();
        dc = done_count;
        wait_done("R9", ok);
        if (ok) check("R9", "rate of first job", rate_hz, 64'd344000000);
        repeat (100) @(negedge clk);
        check("R9", "no second job", 64'(done_count - dc), 64'd1);
        check("R9", "idle afterwards", {63'd0, busy}, 64'd0);

        // R10: reset in mid-job returns to the reset state
        drive_vec(VECS[3]);
        pulse_start();
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", "busy after mid reset", {63'd0, busy}, 64'd0);
        check("R10", "rate after mid reset", rate_hz, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 then recovery: the error clears on the next good job
        drive_vec(VECS[8]);
        pulse_start();
        wait_done("R7", ok);
        if (ok) check("R7", "err set", {63'd0, den_error}, 64'd1);
        @(negedge clk);
        drive_vec(VECS[5]);
        pulse_start();
        wait_done("R7", ok);
        if (ok) begin
            check("R7", "err cleared", {63'd0, den_error}, 64'd0);
            check("R2", "rate after recovery", rate_hz, 64'd1200000000);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule